// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the control and status words that station management sees in a 10/100 Ethernet PHY. It has four 16-bit registers, each selected by a 5-bit address: mode control (address 0), mode status (address 1), ability advertisement (address 4) and negotiation expansion (address 6). Every other address reads as zero. Access goes through a plain synchronous port. Read data is combinational from the address. A read strobe or a write strobe is acted on at the rising clock edge. The port takes one access per cycle and has no back-pressure: `reg_rd` and `reg_wr` are each accepted in the cycle they are high, so no ready signal exists.

Bits in the registers have different access kinds:
- Writable bits hold what software writes.
- Fixed bits hold a constant value.
- Self-clearing bits drop back to 0 when a completion event arrives from the PHY core.
- Latch-high bits stay set until the status word is read.
- The link bit is latch-low: it stays clear until the status word is read.

Reset values come from two places. The two mode strap pins set the speed, duplex and negotiation bits. The strapped PHY address sets the isolate bit.

The PHY core reports its events to this block as single-cycle pulses or as levels. The block drives the mode controls back to the core. It also produces a collision indication for the collision test.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, the control word and the advertisement word depend on `strap_mode`, with a nonzero `strap_addr`. For modes 0, 1, 2 and 3 the control word reads 0x0000, 0x2000, 0x2100 and 0x3100. The advertisement word reads 0x0021, 0x0081, 0x0101 and 0x01E1. Control bit 13 is speed, bit 12 is negotiation enable and bit 8 is duplex. Advertisement bits 8:5 are the abilities and bits 4:0 are the selector, which resets to 00001.
- R2: Control bit 10 (isolate) resets to 1 when `strap_addr` is 00000 and to 0 otherwise. The `isolate` output follows the bit.
- R3: Writing 1 to control bit 15 returns every register, including the latched status bits, to its reset value. Bit 15 and `soft_reset` then read 1 until `core_reset_done` pulses; writing 0 to bit 15 cannot clear it early.
- R4: A write of 1 to control bit 9 (restart) takes effect only when the same write sets bit 12. Once set, bit 9 and `an_restart` stay 1 until `an_started` pulses, and also clear if bit 12 is cleared.
- R5: While bit 12 is 1, `speed_100` and `full_duplex` follow `neg_speed` and `neg_duplex`. While bit 12 is 0, they follow control bits 13 and 8.
- R6: Status bit 2 (link) is latch-low and resets to 0. A cycle with `link_ok` low clears it. A status read while `link_ok` is high reloads it to 1, so the first read after a failure returns 0 even if the link is back.
- R7: Status bit 4 (remote fault, set by `ev_rfault`) and bit 1 (jabber, set by `ev_jabber`) are latch-high. Each is cleared by the edge of a status read.
- R8: Expansion bit 1 (page received) is set by `ev_page_rx` and cleared by a read of address 6. Two reads in a row return 1 and then 0.
- R9: The status word's fixed bits read as 0x7849: bit 15 is 0, bits 14:11, 6, 3 and 0 are 1, and bits 10:7 are 0. Bit 5 follows `an_done` directly.
- R10: Writes to these bits are ignored and the bits read 0:
  - advertisement bits 14, 12:11 and 9
  - control bits 6:0
  - every unmapped address

  Advertisement bits 15, 13, 10 and 8:0 are writable.
- R11: If a latch event occurs in the same cycle as the read that would clear its bit, the event wins. That read returns the old value, and the following read returns the latched value.
- R12: With control bit 7 set, `col_out` rises one cycle after `tx_en` rises and falls one cycle after `tx_en` falls. With bit 7 clear, `col_out` stays 0.
- R13: The outputs `loopback`, `power_down`, `an_enable` and `isolate` follow control bits 14, 11, 12 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_mode | input | 2 | Mode strap pins, sampled for the reset defaults |
| strap_addr | input | 5 | Strapped PHY address |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; drives the clear-on-read actions |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| link_ok | input | 1 | Link level from the core |
| ev_jabber | input | 1 | Jabber event |
| ev_rfault | input | 1 | Remote fault event |
| ev_page_rx | input | 1 | Page received event |
| an_done | input | 1 | Negotiation complete level |
| an_started | input | 1 | Negotiation has begun (clears restart) |
| core_reset_done | input | 1 | Soft reset finished (clears bit 15) |
| neg_speed | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| neg_duplex | input | 1 | Negotiated duplex, 1 = full |
| tx_en | input | 1 | Transmit enable, used for the collision test |
| soft_reset | output | 1 | Soft reset in progress |
| loopback | output | 1 | Loopback control |
| speed_100 | output | 1 | Effective speed |
| full_duplex | output | 1 | Effective duplex |
| an_enable | output | 1 | Negotiation enable |
| isolate | output | 1 | Isolate control |
| power_down | output | 1 | Power-down control |
| an_restart | output | 1 | Restart request held until the core starts |
| col_out | output | 1 | Collision-test indication |

## Verification
The hardest case to reach is an event and the clearing read landing on the same clock edge. A status read with the event held low would simply clear the bit. The stimulus therefore raises the jabber event and the status read strobe in the same cycle. It checks that this read returns 0, the next read returns 1 and the one after that returns 0.

The latch-low link bit needs a one-cycle dropout between two reads while the link level is otherwise high. A soft reset also needs care: it is only visible if earlier writes moved the advertisement word away from its defaults, so those writes are made first.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DW = 16;
  localparam int AW = 5;

  localparam logic [AW-1:0] A_CTRL = 5'd0;
  localparam logic [AW-1:0] A_STAT = 5'd1;
  localparam logic [AW-1:0] A_ADV  = 5'd4;
  localparam logic [AW-1:0] A_EXP  = 5'd6;

  // control bit positions
  localparam int C_RST  = 15;
  localparam int C_LOOP = 14;
  localparam int C_SPD  = 13;
  localparam int C_ANEN = 12;
  localparam int C_PDN  = 11;
  localparam int C_ISO  = 10;
  localparam int C_RSTR = 9;
  localparam int C_DUP  = 8;
  localparam int C_COLT = 7;

  // status bit positions
  localparam int S_ANDONE = 5;
  localparam int S_RF     = 4;
  localparam int S_LINK   = 2;
  localparam int S_JAB    = 1;
  localparam logic [DW-1:0] STAT_FIXED = 16'h7849;

  localparam int E_PAGE = 1;

  localparam logic [DW-1:0] ADV_WMASK = 16'hA5FF;
  localparam logic [4:0]    ADV_SEL   = 5'b00001;

  // number of latch-high status sources
  localparam int NLH = 3;

  function automatic logic [DW-1:0] ctrl_default(input logic [1:0] mode,
                                                 input logic addr_zero);
    logic [DW-1:0] v;
    v         = '0;
    v[C_SPD]  = (mode != 2'd0);
    v[C_ANEN] = (mode == 2'd3);
    v[C_DUP]  = mode[1];
    v[C_ISO]  = addr_zero;
    return v;
  endfunction

  function automatic logic [DW-1:0] adv_default(input logic [1:0] mode);
    logic [DW-1:0] v;
    v      = '0;
    v[4:0] = ADV_SEL;
    case (mode)
      2'd0:    v[5]   = 1'b1;
      2'd1:    v[7]   = 1'b1;
      2'd2:    v[8]   = 1'b1;
      default: v[8:5] = 4'hF;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    strap_mode,
  input  logic [AW-1:0] strap_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          an_started,
  input  logic          reset_done,
  output logic [DW-1:0] ctrl_q,
  output logic          sw_reset
);
  logic [DW-1:0] dflt;

  assign dflt     = ctrl_default(strap_mode, strap_addr == '0);
  assign sw_reset = wr_en & wdata[C_RST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= dflt;
    end else if (sw_reset) begin
      ctrl_q        <= dflt;
      ctrl_q[C_RST] <= 1'b1;
    end else begin
      if (wr_en) begin
        ctrl_q[C_LOOP:C_ISO] <= wdata[C_LOOP:C_ISO];
        ctrl_q[C_DUP:C_COLT] <= wdata[C_DUP:C_COLT];
        ctrl_q[C_RSTR]       <= wdata[C_ANEN] &
                                (wdata[C_RSTR] | (ctrl_q[C_RSTR] & ~an_started));
      end else begin
        ctrl_q[C_RSTR] <= ctrl_q[C_RSTR] & ~an_started & ctrl_q[C_ANEN];
      end
      if (ctrl_q[C_RST] && reset_done) ctrl_q[C_RST] <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_mgmt_adv.sv
module phy_mgmt_adv
  import phy_mgmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    strap_mode,
  input  logic          sw_reset,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] adv_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || sw_reset) adv_q <= adv_default(strap_mode);
    else if (wr_en)         adv_q <= wdata & ADV_WMASK;
  end
endmodule

// File: rtl/phy_mgmt_stat.sv
module phy_mgmt_stat
  import phy_mgmt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sw_reset,
  input  logic [NLH-1:0] lh_event,
  input  logic [NLH-1:0] lh_rd,
  input  logic           link_ok,
  input  logic           stat_rd,
  output logic [NLH-1:0] lh_q,
  output logic           link_q
);
  for (genvar i = 0; i < NLH; i++) begin : g_lh
    always_ff @(posedge clk) begin
      if (!rst_n || sw_reset) lh_q[i] <= 1'b0;
      else if (lh_event[i])   lh_q[i] <= 1'b1;
      else if (lh_rd[i])      lh_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sw_reset) link_q <= 1'b0;
    else if (!link_ok)      link_q <= 1'b0;
    else if (stat_rd)       link_q <= 1'b1;
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  strap_mode,
  input  logic [4:0]  strap_addr,
  input  logic [4:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        link_ok,
  input  logic        ev_jabber,
  input  logic        ev_rfault,
  input  logic        ev_page_rx,
  input  logic        an_done,
  input  logic        an_started,
  input  logic        core_reset_done,
  input  logic        neg_speed,
  input  logic        neg_duplex,
  input  logic        tx_en,
  output logic        soft_reset,
  output logic        loopback,
  output logic        speed_100,
  output logic        full_duplex,
  output logic        an_enable,
  output logic        isolate,
  output logic        power_down,
  output logic        an_restart,
  output logic        col_out
);
  localparam int LH_RF  = 0;
  localparam int LH_JAB = 1;
  localparam int LH_PG  = 2;

  logic [DW-1:0]  ctrl_q, adv_q, stat_w, exp_w;
  logic           sw_reset, link_q, col_q;
  logic           stat_rd, exp_rd;
  logic [NLH-1:0] lh_event, lh_rd, lh_q;

  assign stat_rd  = reg_rd && (reg_addr == A_STAT);
  assign exp_rd   = reg_rd && (reg_addr == A_EXP);
  assign lh_event = {ev_page_rx, ev_jabber, ev_rfault};
  assign lh_rd    = {exp_rd, stat_rd, stat_rd};

  phy_mgmt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .strap_addr(strap_addr),
    .wr_en(reg_wr && (reg_addr == A_CTRL)), .wdata(reg_wdata),
    .an_started(an_started), .reset_done(core_reset_done),
    .ctrl_q(ctrl_q), .sw_reset(sw_reset)
  );

  phy_mgmt_adv u_adv (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .sw_reset(sw_reset),
    .wr_en(reg_wr && (reg_addr == A_ADV)), .wdata(reg_wdata), .adv_q(adv_q)
  );

  phy_mgmt_stat u_stat (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .lh_event(lh_event),
    .lh_rd(lh_rd), .link_ok(link_ok), .stat_rd(stat_rd),
    .lh_q(lh_q), .link_q(link_q)
  );

  always_comb begin
    stat_w           = STAT_FIXED;
    stat_w[S_ANDONE] = an_done;
    stat_w[S_RF]     = lh_q[LH_RF];
    stat_w[S_LINK]   = link_q;
    stat_w[S_JAB]    = lh_q[LH_JAB];
    exp_w            = '0;
    exp_w[E_PAGE]    = lh_q[LH_PG];
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = stat_w;
      A_ADV:   reg_rdata = adv_q;
      A_EXP:   reg_rdata = exp_w;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) col_q <= 1'b0;
    else        col_q <= tx_en & ctrl_q[C_COLT];
  end

  assign col_out     = col_q;
  assign soft_reset  = ctrl_q[C_RST];
  assign loopback    = ctrl_q[C_LOOP];
  assign an_enable   = ctrl_q[C_ANEN];
  assign power_down  = ctrl_q[C_PDN];
  assign isolate     = ctrl_q[C_ISO];
  assign an_restart  = ctrl_q[C_RSTR];
  assign speed_100   = ctrl_q[C_ANEN] ? neg_speed  : ctrl_q[C_SPD];
  assign full_duplex = ctrl_q[C_ANEN] ? neg_duplex : ctrl_q[C_DUP];
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_addr,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        ev_jabber,
  input logic        ev_page_rx,
  input logic        an_started,
  input logic        core_reset_done,
  input logic        neg_speed,
  input logic        neg_duplex,
  input logic        tx_en,
  input logic        soft_reset,
  input logic        speed_100,
  input logic        full_duplex,
  input logic        an_enable,
  input logic        an_restart,
  input logic        col_out
);
  logic rst_wr;
  assign rst_wr = reg_wr && (reg_addr == 5'd0) && reg_wdata[15];

  assert_softreset_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset && !core_reset_done |=> soft_reset);

  assert_restart_needs_an_R4: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |-> an_enable);

  assert_restart_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart && an_started && !(reg_wr && reg_addr == 5'd0) |=> !an_restart);

  assert_negotiated_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    an_enable |-> (speed_100 == neg_speed) && (full_duplex == neg_duplex));

  assert_jabber_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jabber && !rst_wr |=> (reg_addr != 5'd1) || reg_rdata[1]);

  assert_page_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_page_rx && !rst_wr |=> (reg_addr != 5'd6) || reg_rdata[1]);

  assert_col_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_en) |-> !col_out);
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_jabber(ev_jabber),
  .ev_page_rx(ev_page_rx), .an_started(an_started),
  .core_reset_done(core_reset_done), .neg_speed(neg_speed),
  .neg_duplex(neg_duplex), .tx_en(tx_en), .soft_reset(soft_reset),
  .speed_100(speed_100), .full_duplex(full_duplex), .an_enable(an_enable),
  .an_restart(an_restart), .col_out(col_out)
);

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap_mode = 2'd0;
  logic [4:0]  strap_addr = 5'd5;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        link_ok = 1'b0, ev_jabber = 1'b0, ev_rfault = 1'b0, ev_page_rx = 1'b0;
  logic        an_done = 1'b0, an_started = 1'b0, core_reset_done = 1'b0;
  logic        neg_speed = 1'b0, neg_duplex = 1'b0, tx_en = 1'b0;
  logic        soft_reset, loopback, speed_100, full_duplex, an_enable;
  logic        isolate, power_down, an_restart, col_out;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  phy_mgmt_regs u_dut (.*);

  // {strap_mode, control default, advertisement default}  (R1)
  localparam logic [33:0] VEC [4] = '{
    {2'd0, 16'h0000, 16'h0021},
    {2'd1, 16'h2000, 16'h0081},
    {2'd2, 16'h2100, 16'h0101},
    {2'd3, 16'h3100, 16'h01E1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [4:0] a);
    @(negedge clk);
    strap_mode = m; strap_addr = a; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // strap table walk
    for (int i = 0; i < 4; i++) begin
      do_reset(VEC[i][33:32], 5'd5);
      rd_reg(5'd0, rd); check("R1 control default", rd, VEC[i][31:16]);
      rd_reg(5'd4, rd); check("R1 advert default", rd, VEC[i][15:0]);
    end

    // R2 isolate from address 0
    do_reset(2'd3, 5'd0);
    rd_reg(5'd0, rd); check("R2 isolate default", rd, 16'h3500);
    check("R2 isolate out", {15'd0, isolate}, 16'd1);

    // R9 fixed status pattern, an_done live
    do_reset(2'd3, 5'd5);
    rd_reg(5'd1, rd); check("R9 status after reset", rd, 16'h7849);
    an_done = 1'b1;
    rd_reg(5'd1, rd); check("R9 an complete bit", rd, 16'h7869);
    an_done = 1'b0;

    // R5 negotiated mode overrides
    neg_speed = 1'b0; neg_duplex = 1'b0; #1;
    check("R5 neg speed/duplex", {14'd0, speed_100, full_duplex}, 16'd0);
    wr_reg(5'd0, 16'h2100);
    check("R5 forced speed/duplex", {14'd0, speed_100, full_duplex}, 16'd3);

    // R4 restart ignored with negotiation off
    wr_reg(5'd0, 16'h0200);
    rd_reg(5'd0, rd); check("R4 restart ignored", rd, 16'h0000);
    wr_reg(5'd0, 16'h1200);
    rd_reg(5'd0, rd); check("R4 restart held", rd, 16'h1200);
    pulse(an_started);
    rd_reg(5'd0, rd); check("R4 restart self-clear", rd, 16'h1000);

    // R13 control outputs
    wr_reg(5'd0, 16'h4C00);
    check("R13 outputs", {12'd0, loopback, power_down, isolate, an_enable}, 16'hE);

    // R10 reserved bits
    wr_reg(5'd4, 16'hFFFF);
    rd_reg(5'd4, rd); check("R10 advert mask", rd, 16'hA5FF);
    wr_reg(5'd0, 16'h00FF);
    rd_reg(5'd0, rd); check("R10 control reserved", rd, 16'h0080);
    wr_reg(5'd2, 16'hFFFF);
    rd_reg(5'd2, rd); check("R10 unmapped", rd, 16'h0000);

    // R12 collision test (bit 7 currently set)
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk); check("R12 col rise", {15'd0, col_out}, 16'd1);
    tx_en = 1'b0;
    @(negedge clk); check("R12 col fall", {15'd0, col_out}, 16'd0);
    wr_reg(5'd0, 16'h0000);
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk); check("R12 col disabled", {15'd0, col_out}, 16'd0);
    tx_en = 1'b0;

    // R3 soft reset
    wr_reg(5'd4, 16'h0000);
    wr_reg(5'd0, 16'h8000);
    rd_reg(5'd0, rd); check("R3 reset pending", rd, 16'hB100);
    rd_reg(5'd4, rd); check("R3 advert restored", rd, 16'h01E1);
    wr_reg(5'd0, 16'h0000);
    check("R3 write cannot clear", {15'd0, soft_reset}, 16'd1);
    pulse(core_reset_done);
    rd_reg(5'd0, rd); check("R3 reset done", rd, 16'h0000);

    // R6 latch-low link
    do_reset(2'd0, 5'd5);
    link_ok = 1'b1;
    rd_reg(5'd1, rd); check("R6 first read low", rd & 16'h0004, 16'h0000);
    rd_reg(5'd1, rd); check("R6 second read high", rd & 16'h0004, 16'h0004);
    pulse(link_ok);  // toggles high->? not used for dropout
    link_ok = 1'b1;
    @(negedge clk); link_ok = 1'b0;
    @(negedge clk); link_ok = 1'b1;
    rd_reg(5'd1, rd); check("R6 dropout latched", rd & 16'h0004, 16'h0000);
    rd_reg(5'd1, rd); check("R6 recovered", rd & 16'h0004, 16'h0004);

    // R7 latch-high
    pulse(ev_jabber);
    rd_reg(5'd1, rd); check("R7 jabber set", rd & 16'h0002, 16'h0002);
    rd_reg(5'd1, rd); check("R7 jabber cleared", rd & 16'h0002, 16'h0000);
    pulse(ev_rfault);
    rd_reg(5'd1, rd); check("R7 rfault set", rd & 16'h0010, 16'h0010);
    rd_reg(5'd1, rd); check("R7 rfault cleared", rd & 16'h0010, 16'h0000);

    // R8 page received
    pulse(ev_page_rx);
    rd_reg(5'd6, rd); check("R8 page first read", rd, 16'h0002);
    rd_reg(5'd6, rd); check("R8 page second read", rd, 16'h0000);

    // R11 event and clearing read in the same cycle
    @(negedge clk);
    reg_addr = 5'd1; reg_rd = 1'b1; ev_jabber = 1'b1;
    #1 check("R11 same-cycle read old", reg_rdata & 16'h0002, 16'h0000);
    @(negedge clk);
    ev_jabber = 1'b0; reg_rd = 1'b0;
    rd_reg(5'd1, rd); check("R11 event kept", rd & 16'h0002, 16'h0002);
    rd_reg(5'd1, rd); check("R11 then cleared", rd & 16'h0002, 16'h0000);

    report();
  end
endmodule